// File: doc/BRIEF.md
# Border Restoring Pixel Feeder

This stage sits after a 3×3 window filter in a streaming image pipeline. The window filter can only produce a result where its whole window lies inside the picture, so for a frame of `FRAME_W` × `FRAME_H` pixels it delivers just the interior, (`FRAME_W`-2) × (`FRAME_H`-2) pixels in raster order. Each of those results belongs to the centre of its window, which sits one row and one column below and to the right of where the stream alone would place it. The feeder takes that shaved stream, stores it in a two-line buffer and emits a full-size frame aligned to the original coordinates. Every border position is filled with a copy of the nearest interior pixel.

The upstream side is a valid/ready stream with a start-of-frame flag on the first pixel. The downstream side is a valid-only stream with start-of-frame and end-of-line flags, intended for a memory writer that bursts one pixel per clock. Within a row the output never pauses. When the upstream delivers a pixel on every cycle it is ready, the whole frame comes out without a gap. The last output row is built entirely from data already buffered, and the upstream is held off while it plays out.

Top module: `border_feeder`

## Requirements
- R1: For each input frame of (FRAME_W-2)×(FRAME_H-2) pixels, exactly FRAME_W×FRAME_H output pixels are produced, in raster order.
- R2: An output pixel at row r and column c, with 1 ≤ r ≤ FRAME_H-2 and 1 ≤ c ≤ FRAME_W-2, equals input pixel (r-1, c-1). Input coordinates count rows and columns of the shaved stream from 0.
- R3: Border output pixels take the value of the nearest interior position. The row index is clamped to the range 1..FRAME_H-2 and the column index to 1..FRAME_W-2, and R2 is then applied; corners therefore copy the interior corners.
- R4: out_sof is 1 exactly with output pixel (0,0) of each frame. out_eol is 1 exactly with the pixel in column FRAME_W-1 of every row. Neither flag is ever 1 while out_valid is 0.
- R5: Inside a row, out_valid is 1 on consecutive cycles from column 0 to column FRAME_W-1. When the upstream presents a pixel on every cycle that in_ready is 1, the last pixel of the frame appears exactly FRAME_W×FRAME_H-1 cycles after the out_sof pixel.
- R6: When no frame is in progress, a pixel offered with in_sof = 0 is accepted (in_ready = 1) and discarded. The pixel offered with in_sof = 1 becomes input pixel (0,0).
- R7: While the last output row is being produced, in_ready is 0 on every cycle up to, but not including, the cycle that carries the row's final pixel.
- R8: With idle cycles inserted in the upstream stream, the output values still satisfy R2 and R3. Gaps in the output appear only between rows.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream pixel present |
| in_ready | output | 1 | Feeder accepts the upstream pixel this cycle |
| in_sof | input | 1 | Marks the first interior pixel of a frame |
| in_data | input | PIX_W | Upstream interior pixel |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | First pixel of the restored frame |
| out_eol | output | 1 | Last pixel of an output row |
| out_data | output | PIX_W | Restored pixel |

## Verification
A wrong bank select or a stale read pointer shows up as an output value that differs from the clamped reference. This appears within one row of the fault, and usually on the very pixel that read the wrong line. An error in the row or column counters moves out_eol or out_sof away from their positions, or breaks the gap-free timing of a full-rate frame, and the checker reports this on the cycle it happens. A fault in the flow-control rule either lets the upstream overwrite a line that is still being read, which corrupts values in the next row, or holds the upstream off so long that the frame stops producing output and the per-frame pixel count comes up short.

// File: rtl/bfeed_pkg.sv
// Shared types and index mapping for the border restoring feeder.
// Assumes a 3x3 upstream window, i.e. one pixel of shave on every side.
package bfeed_pkg;

    // Output stream flags that travel alongside the pixel
    typedef struct packed {
        logic sof;
        logic eol;
    } mark_t;

    // Map an output index (0..last) to the interior index that feeds it:
    // the border positions clamp to the nearest interior position.
    function automatic int unsigned clamp_src(input int unsigned pos, input int unsigned last);
        if (pos == 0)
            return 0;
        else if (pos >= last)
            return last - 2;
        else
            return pos - 1;
    endfunction

endpackage

// File: rtl/bfeed_line_store.sv
// Two-bank line buffer. Bank b holds the interior rows with row[0] == b.
// One write port and one registered read port; the controllers never
// write the bank being read in the same cycle.
module bfeed_line_store #(
    parameter int PIX_W  = 8,
    parameter int DEPTH  = 30,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIX_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  rd_data
);

    logic [PIX_W-1:0] bank_q [2];
    logic             sel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [PIX_W-1:0] mem [DEPTH];

        // Store one incoming interior pixel into this bank
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                mem[wr_addr] <= wr_data;
        end

        // Registered read of this bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= '0;
            else if (rd_en && (rd_bank == 1'(b)))
                bank_q[b] <= mem[rd_addr];
        end
    end

    // Remember which bank the registered data came from
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if (rd_en)
            sel_q <= rd_bank;
    end

    assign rd_data = bank_q[sel_q];

endmodule

// File: rtl/bfeed_fill_ctrl.sv
// Write side: accepts the shaved interior stream and files each row into
// the bank chosen by its row parity. Row k (k >= 2) may only be written
// once the output scan has reached row k, since the bank still holds
// row k-2 until then. Pixels arriving between frames without the
// start-of-frame flag are taken and dropped.
module bfeed_fill_ctrl #(
    parameter int IN_W   = 30,
    parameter int IN_H   = 22,
    parameter int ADDR_W = 5,
    parameter int ROW_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [ROW_W-1:0]  out_row,
    input  logic              frame_done,
    output logic              in_ready,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ROW_W-1:0]  rows_loaded
);

    localparam logic [ADDR_W-1:0] LAST_COL = ADDR_W'(IN_W - 1);
    localparam logic [ROW_W-1:0]  ALL_ROWS = ROW_W'(IN_H);
    localparam logic [ROW_W-1:0]  FREE_ROWS = ROW_W'(2);

    logic              armed;
    logic [ADDR_W-1:0] col;
    logic [ROW_W-1:0]  row;

    // Decide whether the next interior pixel has a free slot
    always_comb begin
        if (!armed)
            in_ready = 1'b1;
        else
            in_ready = (row < ALL_ROWS) && ((row < FREE_ROWS) || (out_row >= row));
    end

    assign wr_en       = in_valid && in_ready && (armed || in_sof);
    assign wr_bank     = row[0];
    assign wr_addr     = col;
    assign rows_loaded = row;

    // Advance the write position; rearm for the next frame when output ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            col   <= '0;
            row   <= '0;
        end else if (frame_done) begin
            armed <= 1'b0;
            col   <= '0;
            row   <= '0;
        end else if (wr_en) begin
            armed <= 1'b1;
            if (col == LAST_COL) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bfeed_scan_ctrl.sv
// Read side: walks the full-size output frame one pixel per clock and
// maps each position to a buffered interior pixel with clamped indices.
// A row starts only when its source row is complete, so a started row
// always runs to its end without a pause.
module bfeed_scan_ctrl
    import bfeed_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int FRAME_H = 24,
    parameter int COL_W   = 5,
    parameter int ROW_W   = 5,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rows_loaded,
    output logic [ROW_W-1:0]  out_row,
    output logic              rd_en,
    output logic              rd_bank,
    output logic [ADDR_W-1:0] rd_addr,
    output mark_t             mark,
    output logic              frame_done
);

    localparam int unsigned LAST_C = FRAME_W - 1;
    localparam int unsigned LAST_R = FRAME_H - 1;

    logic             active;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;

    int unsigned src_r, src_c, nxt_r, need_now, need_next;
    logic        end_col, last_row, start_ok, cont_ok;

    // Source indices and the row-availability tests
    always_comb begin
        src_r     = clamp_src(32'(row), LAST_R);
        src_c     = clamp_src(32'(col), LAST_C);
        end_col   = (32'(col) == LAST_C);
        last_row  = (32'(row) == LAST_R);
        nxt_r     = last_row ? 0 : 32'(row) + 1;
        need_now  = src_r + 1;
        need_next = clamp_src(nxt_r, LAST_R) + 1;
        start_ok  = (32'(rows_loaded) >= need_now);
        cont_ok   = (32'(rows_loaded) >= need_next);
    end

    assign out_row    = row;
    assign rd_en      = active;
    assign rd_bank    = src_r[0];
    assign rd_addr    = ADDR_W'(src_c);
    assign mark.sof   = (row == '0) && (col == '0);
    assign mark.eol   = end_col;
    assign frame_done = active && end_col && last_row;

    // Step through the output frame, pausing only at row boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            col    <= '0;
            row    <= '0;
        end else if (!active) begin
            if (start_ok)
                active <= 1'b1;
        end else if (end_col) begin
            col <= '0;
            if (last_row) begin
                row    <= '0;
                active <= 1'b0;
            end else begin
                row    <= row + 1'b1;
                active <= cont_ok;
            end
        end else begin
            col <= col + 1'b1;
        end
    end

endmodule

// File: rtl/border_feeder.sv
// Border restoring pixel feeder: turns the shaved interior stream of a
// 3x3 window stage back into a full FRAME_W x FRAME_H frame at original
// alignment, replicating the nearest interior pixel into the border.
// Assumes FRAME_W >= 4 and FRAME_H >= 4; output has no backpressure.
module border_feeder
    import bfeed_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int FRAME_H = 24,
    parameter int PIX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_data,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eol,
    output logic [PIX_W-1:0] out_data
);

    localparam int IN_W   = FRAME_W - 2;
    localparam int IN_H   = FRAME_H - 2;
    localparam int ADDR_W = $clog2(IN_W);
    localparam int COL_W  = $clog2(FRAME_W);
    localparam int ROW_W  = $clog2(FRAME_H);

    logic              wr_en, wr_bank, rd_en, rd_bank, frame_done;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [ROW_W-1:0]  rows_loaded, out_row;
    mark_t             mark;

    bfeed_fill_ctrl #(
        .IN_W(IN_W), .IN_H(IN_H), .ADDR_W(ADDR_W), .ROW_W(ROW_W)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .out_row(out_row), .frame_done(frame_done), .in_ready(in_ready),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .rows_loaded(rows_loaded)
    );

    bfeed_scan_ctrl #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .COL_W(COL_W),
        .ROW_W(ROW_W), .ADDR_W(ADDR_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .rows_loaded(rows_loaded),
        .out_row(out_row), .rd_en(rd_en), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .mark(mark), .frame_done(frame_done)
    );

    bfeed_line_store #(
        .PIX_W(PIX_W), .DEPTH(IN_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(in_data), .rd_en(rd_en),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(out_data)
    );

    // Delay valid and flags by one cycle to line up with the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_sof   <= rd_en && mark.sof;
            out_eol   <= rd_en && mark.eol;
        end
    end

endmodule

// File: rtl/border_feeder_checker.sv
// Port-level protocol checker for border_feeder. Tracks the output
// position with its own counters and checks flag placement, row
// continuity and upstream hold-off during the last row.
module border_feeder_checker #(
    parameter int FRAME_W = 32,
    parameter int FRAME_H = 24
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_sof,
    input logic out_eol
);

    int o_col;
    int o_row;

    // Count output positions seen at the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_col <= 0;
            o_row <= 0;
        end else if (out_valid) begin
            if (o_col == FRAME_W - 1) begin
                o_col <= 0;
                o_row <= (o_row == FRAME_H - 1) ? 0 : o_row + 1;
            end else begin
                o_col <= o_col + 1;
            end
        end
    end

    // R4: start-of-frame only on a valid pixel at the frame origin
    assert_sof_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && o_col == 0 && o_row == 0));

    // R4: end-of-line exactly on the last column
    assert_eol_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_eol == (o_col == FRAME_W - 1)));

    // R4: no end-of-line flag without a pixel
    assert_eol_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    // R5: a started row runs without a pause
    assert_row_unbroken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eol) |=> out_valid);

    // R7: upstream held off while the last row plays out
    assert_tail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_row == FRAME_H - 1 && !out_eol) |-> !in_ready);

endmodule

bind border_feeder border_feeder_checker #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H)
) u_check (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/border_feeder_test.sv
// Scoreboard bench: the driver queues the full expected frame, then feeds
// the shaved interior; a monitor pops and compares every output pixel.
module border_feeder_test;

    localparam int W = 32;
    localparam int H = 24;
    localparam int IW = W - 2;
    localparam int IH = H - 2;

    typedef struct {
        int         fid;
        int         r;
        int         c;
        logic [7:0] d;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, out_sof, out_eol;
    logic [7:0] out_data;

    exp_t q[$];
    exp_t e;
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done = 0;
    bit   full_rate [8];
    int   f_first, f_count, f_err, f_tail_bad;
    string tag;

    border_feeder #(.FRAME_W(W), .FRAME_H(H), .PIX_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    function automatic logic [7:0] pixval(input int f, input int r, input int c);
        return 8'((f * 37 + r * 11 + c * 5) & 255);
    endfunction

    function automatic int src_of(input int p, input int n);
        if (p == 0) return 0;
        if (p >= n - 2) return n - 3;
        return p - 1;
    endfunction

    task automatic drive_px(input logic [7:0] d, input logic s);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_sof   = s;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic send_frame(input int fid, input bit stall);
        exp_t x;
        full_rate[fid] = !stall;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                x.fid = fid; x.r = r; x.c = c;
                x.d = pixval(fid, src_of(r, H), src_of(c, W));
                q.push_back(x);
            end
        for (int r = 0; r < IH; r++)
            for (int c = 0; c < IW; c++) begin
                if (stall && (c % 3 == 2)) go_idle();
                drive_px(pixval(fid, r, c), (r == 0 && c == 0));
            end
        go_idle();
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) drive_px(8'hEE, 1'b0);
        go_idle();
    endtask

    // Monitor: compare each output pixel with the queued reference
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R1", "unexpected output pixel", 1, 0);
            end else begin
                e = q.pop_front();
                if (e.r == 0 && e.c == 0) begin
                    f_first = cyc; f_count = 0; f_err = 0; f_tail_bad = 0;
                end
                f_count++;
                tag = (e.r == 0 || e.r == H - 1 || e.c == 0 || e.c == W - 1) ? "R3" : "R2";
                chk(out_data == e.d, tag, $sformatf("pixel f%0d r%0d c%0d", e.fid, e.r, e.c),
                    int'(out_data), int'(e.d));
                if (out_data != e.d) f_err++;
                chk(out_sof == (e.r == 0 && e.c == 0), "R4", "out_sof flag",
                    int'(out_sof), int'(e.r == 0 && e.c == 0));
                chk(out_eol == (e.c == W - 1), "R4", "out_eol flag",
                    int'(out_eol), int'(e.c == W - 1));
                if (e.r == H - 1 && e.c < W - 1 && in_ready) f_tail_bad++;
                if (e.r == H - 1 && e.c == W - 1) begin
                    chk(f_count == W * H, "R1", "pixels per frame", f_count, W * H);
                    chk(f_tail_bad == 0, "R7", "in_ready high in last row", f_tail_bad, 0);
                    if (full_rate[e.fid])
                        chk(cyc - f_first == W * H - 1, "R5", "full-rate frame duration",
                            cyc - f_first, W * H - 1);
                    if (e.fid == 1)
                        chk(f_err == 0, "R6", "frame after dropped junk", f_err, 0);
                    if (e.fid == 2)
                        chk(f_err == 0, "R8", "frame with upstream stalls", f_err, 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
        send_frame(0, 1'b0);
        send_junk(5);
        send_frame(1, 1'b0);
        send_frame(2, 1'b1);
        send_frame(3, 1'b0);
        while (q.size() != 0 && !done) @(negedge clk);
        repeat (4) @(negedge clk);
        if (!done) begin
            chk(out_valid == 1'b0, "R1", "no output after last frame", int'(out_valid), 0);
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule